// File: doc/BRIEF.md
# Byte Register File with Pair Port

This block stores the working bytes of a small 8-bit processor datapath. It holds seven byte-wide registers: an accumulator, four general registers and a high/low pair that together form a 16-bit memory pointer. Each register answers to a 3-bit code. One byte write port and one byte read port each take their own code, so a single cycle can read one register and write another. That is all a register-to-register copy needs. One code value names no register. It is kept for the memory operand that the pair points at, and the block ignores it on both ports.

Three controls give the accumulator paths that do not depend on the codes. Its value is always on a dedicated output. A load control stores the input byte into it whatever the write code is. A read control puts it on the byte read port whatever the read code is. The pointer pair has a 16-bit side port. A steering control selects whether the high and low registers take their input from the byte input or from the two halves of a 16-bit input. A pair-load control writes both registers in one cycle. A pair-read control presents the two bytes as one 16-bit word. The read outputs each carry a valid flag in place of a tri-state enable. A valid output is driven as data; an invalid one returns zero.

Top module: `byte_pair_regfile`

## Requirements
- R1: After an active-low reset, every one of the seven registers reads back as 0x00, and the accumulator output is 0x00.
- R2: Register codes are 000 general0, 001 general1, 010 general2, 011 general3, 100 pair-high, 101 pair-low and 111 accumulator. A write strobe stores the write byte into the coded register on the rising clock edge.
- R3: With read enable high and a code other than 110, the read port returns the coded register with the valid flag set. Reads are combinational, so a read of a register being written in the same cycle returns the old value. A register copied from another holds the same value afterwards, and the source is unchanged.
- R4: Code 110 names no register. A write strobe with that code changes no register. A read with that code, and without the accumulator read control, leaves the valid flag low and the data at zero.
- R5: The accumulator output equals the accumulator register in every cycle, whatever the read code and enables are.
- R6: The accumulator load control stores the write byte in the accumulator, whatever the write code and strobe are. A strobe to another register in the same cycle also takes effect.
- R7: The accumulator read control puts the accumulator on the read port with the valid flag set. It takes priority over the read code.
- R8: With the wide-steering control high, the pair-load control stores bits 15:8 of the 16-bit input in pair-high and bits 7:0 in pair-low, both in the same cycle.
- R9: The steering control also applies to byte writes. When it is high, a byte strobe to pair-high or pair-low stores the matching half of the 16-bit input. When it is low, a pair-load stores the write byte into both registers.
- R10: The pair read control drives {pair-high, pair-low} on the 16-bit output with its valid flag set. Without it the output is zero and not valid.
- R11: With neither read enable nor the accumulator read control, the byte read port is zero and not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Byte to be written |
| wr_sel | input | 3 | Register code for the byte write |
| wr_strobe | input | 1 | Write the coded register |
| acc_load | input | 1 | Write the accumulator regardless of code |
| rd_sel | input | 3 | Register code for the byte read |
| rd_en | input | 1 | Read the coded register |
| acc_rd_en | input | 1 | Read the accumulator regardless of code |
| rd_data | output | 8 | Byte read data, zero when not valid |
| rd_valid | output | 1 | Byte read port is driving |
| acc_out | output | 8 | Accumulator, always presented |
| pair_wr_data | input | 16 | Word for the pointer pair (high byte first) |
| pair_src_wide | input | 1 | Pair registers take their input from the 16-bit word |
| pair_load | input | 1 | Write both pair registers |
| pair_rd_en | input | 1 | Drive the pair onto the 16-bit read port |
| pair_rd_data | output | 16 | {pair-high, pair-low}, zero when not valid |
| pair_rd_valid | output | 1 | 16-bit read port is driving |

## Verification
The case hardest to reach from the ports is a register whose input has several sources in the same cycle. Examples are a byte strobe to pair-high while the steering control selects the wide word, or a pair-load while steering selects the byte input, or an accumulator load together with a strobe to another code. Directed steps set up each of these combinations, and each is then read back through the byte and pair ports. A long run of random control words then covers overlaps that the directed steps miss. A behavioural model in the bench is compared with every output on every clock.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int N_CODES  = 1 << SEL_W;
    localparam int PAIR_W   = 2 * DATA_W;

    typedef enum logic [SEL_W-1:0] {
        CODE_G0  = 3'b000,
        CODE_G1  = 3'b001,
        CODE_G2  = 3'b010,
        CODE_G3  = 3'b011,
        CODE_HI  = 3'b100,
        CODE_LO  = 3'b101,
        CODE_MEM = 3'b110,
        CODE_ACC = 3'b111
    } reg_code_e;

    localparam int IDX_HI  = int'(CODE_HI);
    localparam int IDX_LO  = int'(CODE_LO);
    localparam int IDX_MEM = int'(CODE_MEM);
    localparam int IDX_ACC = int'(CODE_ACC);
endpackage

// File: rtl/rf_decoder.sv
module rf_decoder #(
    parameter int SEL_W = 3,
    parameter int N_OUT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic [N_OUT-1:0] hit
);
    always_comb begin
        hit = '0;
        for (int i = 0; i < N_OUT; i++) begin
            if (en && (sel == SEL_W'(i))) begin
                hit[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rf_byte_reg.sv
module rf_byte_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel #(
    parameter int W = 8,
    parameter int N = 8
) (
    input  logic [N-1:0][W-1:0] regs,
    input  logic [N-1:0]        drive,
    output logic [W-1:0]        data,
    output logic                valid
);
    always_comb begin
        data  = '0;
        valid = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (drive[i]) begin
                data  = data | regs[i];
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/byte_pair_regfile.sv
module byte_pair_regfile
    import rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_strobe,
    input  logic              acc_load,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              rd_en,
    input  logic              acc_rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] acc_out,
    input  logic [PAIR_W-1:0] pair_wr_data,
    input  logic              pair_src_wide,
    input  logic              pair_load,
    input  logic              pair_rd_en,
    output logic [PAIR_W-1:0] pair_rd_data,
    output logic              pair_rd_valid
);
    logic [N_CODES-1:0]             wr_hit;
    logic [N_CODES-1:0]             rd_hit;
    logic [N_CODES-1:0]             rd_drive;
    logic [N_CODES-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]              hi_in;
    logic [DATA_W-1:0]              lo_in;
    logic                           unused_mem_strobe;

    rf_decoder #(.SEL_W(SEL_W), .N_OUT(N_CODES)) u_wr_dec (
        .sel (wr_sel),
        .en  (wr_strobe),
        .hit (wr_hit)
    );

    rf_decoder #(.SEL_W(SEL_W), .N_OUT(N_CODES)) u_rd_dec (
        .sel (rd_sel),
        .en  (rd_en),
        .hit (rd_hit)
    );

    // Steering of the pointer-pair inputs between byte and word sources.
    always_comb begin
        if (pair_src_wide) begin
            hi_in = pair_wr_data[PAIR_W-1:DATA_W];
            lo_in = pair_wr_data[DATA_W-1:0];
        end else begin
            hi_in = wr_data;
            lo_in = wr_data;
        end
    end

    assign unused_mem_strobe = wr_hit[IDX_MEM];

    for (genvar i = 0; i < N_CODES; i++) begin : g_slot
        if (i == IDX_MEM) begin : g_mem
            assign regs_q[i] = '0;
        end else begin : g_reg
            logic              slot_load;
            logic [DATA_W-1:0] slot_d;
            if (i == IDX_ACC) begin : g_acc
                assign slot_load = wr_hit[i] | acc_load;
                assign slot_d    = wr_data;
            end else if (i == IDX_HI) begin : g_hi
                assign slot_load = wr_hit[i] | pair_load;
                assign slot_d    = hi_in;
            end else if (i == IDX_LO) begin : g_lo
                assign slot_load = wr_hit[i] | pair_load;
                assign slot_d    = lo_in;
            end else begin : g_gen
                assign slot_load = wr_hit[i];
                assign slot_d    = wr_data;
            end
            rf_byte_reg #(.W(DATA_W)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (slot_load),
                .d     (slot_d),
                .q     (regs_q[i])
            );
        end
    end

    // Accumulator read takes the port outright; the memory code drives nothing.
    always_comb begin
        if (acc_rd_en) begin
            rd_drive          = '0;
            rd_drive[IDX_ACC] = 1'b1;
        end else begin
            rd_drive          = rd_hit;
            rd_drive[IDX_MEM] = 1'b0;
        end
    end

    rf_read_sel #(.W(DATA_W), .N(N_CODES)) u_rd_sel (
        .regs  (regs_q),
        .drive (rd_drive),
        .data  (rd_data),
        .valid (rd_valid)
    );

    assign acc_out       = regs_q[IDX_ACC];
    assign pair_rd_valid = pair_rd_en;
    assign pair_rd_data  = pair_rd_en ? {regs_q[IDX_HI], regs_q[IDX_LO]} : '0;
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] wr_data,
    input logic [SEL_W-1:0]  wr_sel,
    input logic              wr_strobe,
    input logic              acc_load,
    input logic [SEL_W-1:0]  rd_sel,
    input logic              acc_rd_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] acc_out,
    input logic [PAIR_W-1:0] pair_wr_data,
    input logic              pair_src_wide,
    input logic              pair_load,
    input logic              pair_rd_en,
    input logic [PAIR_W-1:0] pair_rd_data,
    input logic              pair_rd_valid
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_out == '0));

    assert_mem_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == CODE_MEM && !acc_rd_en) |-> (!rd_valid && rd_data == '0));

    assert_mem_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_strobe && wr_sel == CODE_MEM && !acc_load) |-> $stable(acc_out));

    assert_acc_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && acc_load) |-> (acc_out == $past(wr_data)));

    assert_acc_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd_en |-> (rd_valid && rd_data == acc_out));

    assert_pair_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && pair_load && pair_src_wide) && pair_rd_en)
            |-> (pair_rd_valid && pair_rd_data == $past(pair_wr_data)));

    assert_pair_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_rd_en |-> (!pair_rd_valid && pair_rd_data == '0));

    assert_read_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !acc_rd_en) |-> (!rd_valid && rd_data == '0));
endmodule

bind byte_pair_regfile rf_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_data       (wr_data),
    .wr_sel        (wr_sel),
    .wr_strobe     (wr_strobe),
    .acc_load      (acc_load),
    .rd_sel        (rd_sel),
    .acc_rd_en     (acc_rd_en),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .acc_out       (acc_out),
    .pair_wr_data  (pair_wr_data),
    .pair_src_wide (pair_src_wide),
    .pair_load     (pair_load),
    .pair_rd_en    (pair_rd_en),
    .pair_rd_data  (pair_rd_data),
    .pair_rd_valid (pair_rd_valid)
);

// File: tb/sim_byte_pair_regfile.sv
module sim_byte_pair_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  wr_sel = '0;
    logic        wr_strobe = 1'b0;
    logic        acc_load = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic        rd_en = 1'b0;
    logic        acc_rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [7:0]  acc_out;
    logic [15:0] pair_wr_data = '0;
    logic        pair_src_wide = 1'b0;
    logic        pair_load = 1'b0;
    logic        pair_rd_en = 1'b0;
    logic [15:0] pair_rd_data;
    logic        pair_rd_valid;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];
    logic [7:0] seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_pair_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_sel(wr_sel),
        .wr_strobe(wr_strobe), .acc_load(acc_load), .rd_sel(rd_sel),
        .rd_en(rd_en), .acc_rd_en(acc_rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .acc_out(acc_out), .pair_wr_data(pair_wr_data),
        .pair_src_wide(pair_src_wide), .pair_load(pair_load),
        .pair_rd_en(pair_rd_en), .pair_rd_data(pair_rd_data),
        .pair_rd_valid(pair_rd_valid)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Compare every output with the model, then advance the model one edge.
    task automatic step(input string tag,
                        input logic [2:0] ws, input logic we, input logic al, input logic [7:0] wd,
                        input logic [2:0] rs, input logic re, input logic ae,
                        input logic [15:0] pd, input logic pw, input logic pl, input logic pe);
        logic [7:0] e_rd;
        logic       e_rv;
        logic [7:0] h_in;
        logic [7:0] l_in;
        logic [7:0] nxt [8];
        wr_sel = ws; wr_strobe = we; acc_load = al; wr_data = wd;
        rd_sel = rs; rd_en = re; acc_rd_en = ae;
        pair_wr_data = pd; pair_src_wide = pw; pair_load = pl; pair_rd_en = pe;
        #1;
        if (ae) begin
            e_rd = model[7]; e_rv = 1'b1;
        end else if (re && rs != 3'd6) begin
            e_rd = model[rs]; e_rv = 1'b1;
        end else begin
            e_rd = 8'h00; e_rv = 1'b0;
        end
        check(tag, "rd_data", {8'h00, rd_data}, {8'h00, e_rd});
        check(tag, "rd_valid", {15'h0, rd_valid}, {15'h0, e_rv});
        check(tag, "acc_out", {8'h00, acc_out}, {8'h00, model[7]});
        check(tag, "pair_rd_data", pair_rd_data, pe ? {model[4], model[5]} : 16'h0000);
        check(tag, "pair_rd_valid", {15'h0, pair_rd_valid}, {15'h0, pe});
        seen = rd_data;
        h_in = pw ? pd[15:8] : wd;
        l_in = pw ? pd[7:0]  : wd;
        for (int i = 0; i < 8; i++) nxt[i] = model[i];
        if (we && ws != 3'd6) begin
            if (ws == 3'd4)      nxt[4] = h_in;
            else if (ws == 3'd5) nxt[5] = l_in;
            else                 nxt[ws] = wd;
        end
        if (al) nxt[7] = wd;
        if (pl) begin
            nxt[4] = h_in;
            nxt[5] = l_in;
        end
        @(posedge clk);
        for (int i = 0; i < 8; i++) model[i] = nxt[i];
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input logic [2:0] s, input logic [7:0] d);
        step(tag, s, 1'b1, 1'b0, d, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd(input string tag, input logic [2:0] s);
        step(tag, 3'd0, 1'b0, 1'b0, 8'h00, s, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        @(negedge clk);
        #1;
        check("R1", "acc_out in reset", {8'h00, acc_out}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i++) rd("R1", 3'(i));
        // R2: code map, distinct value per register
        for (int i = 0; i < 8; i++) if (i != 6) wr("R2", 3'(i), 8'(8'h10 + 8'(i * 17)));
        for (int i = 0; i < 8; i++) rd("R2", 3'(i));
        // R4: write with memory code changes nothing, read with it drives nothing
        wr("R4", 3'd6, 8'hEE);
        for (int i = 0; i < 8; i++) rd("R4", 3'(i));
        // R3: same-cycle write and read returns the old value
        step("R3", 3'd1, 1'b1, 1'b0, 8'h11, 3'd1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        rd("R3", 3'd1);
        // R3: copy general0 into pair-low; source unchanged
        rd("R3", 3'd0);
        wr("R3", 3'd5, seen);
        rd("R3", 3'd5);
        rd("R3", 3'd0);
        // R6: accumulator load alongside a strobe to another code
        step("R6", 3'd2, 1'b1, 1'b1, 8'h5A, 3'd7, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        step("R6", 3'd6, 1'b0, 1'b1, 8'hC3, 3'd2, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        rd("R6", 3'd7);
        rd("R6", 3'd2);
        // R7: accumulator read overrides the code
        step("R7", 3'd0, 1'b0, 1'b0, 8'h00, 3'd3, 1'b1, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);
        step("R7", 3'd0, 1'b0, 1'b0, 8'h00, 3'd6, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);
        // R8: word load of the pair
        step("R8", 3'd0, 1'b0, 1'b0, 8'h77, 3'd0, 1'b0, 1'b0, 16'hABCD, 1'b1, 1'b1, 1'b0);
        rd("R8", 3'd4);
        rd("R8", 3'd5);
        // R9: steering applies to byte strobes and to pair-load from the byte input
        step("R9", 3'd4, 1'b1, 1'b0, 8'h01, 3'd0, 1'b0, 1'b0, 16'h9F2E, 1'b1, 1'b0, 1'b1);
        step("R9", 3'd5, 1'b1, 1'b0, 8'h02, 3'd0, 1'b0, 1'b0, 16'h9F2E, 1'b1, 1'b0, 1'b1);
        step("R9", 3'd0, 1'b0, 1'b0, 8'h3C, 3'd0, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b1);
        rd("R9", 3'd4);
        // R10 and R11: idle ports
        step("R10", 3'd0, 1'b0, 1'b0, 8'h00, 3'd4, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        step("R11", 3'd0, 1'b0, 1'b0, 8'h00, 3'd7, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        // R5 and the rest under random control words
        for (int n = 0; n < 3000; n++) begin
            step("R5 random", 3'($urandom), 1'($urandom), 1'($urandom % 4 == 0), 8'($urandom),
                 3'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                 16'($urandom), 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom));
        end
        finish_run();
    end
endmodule